// File: doc/BRIEF.md
# Recursive Trapezoidal Energy Shaper

This block takes the raw sample stream of a transistor-reset charge preamplifier, digitized as signed 20-bit words with no analog shaping in front. Each photon adds a small step to a slowly rising ramp, and the preamplifier returns to a low level now and then through a sharp reset drop. The block forms a trapezoid from every step with a recursive filter. The filter takes two delay-line differences and feeds them to an accumulator. Rise length `k` and flat-top length `m` are set at run time, in samples. A short-lag difference of the input triggers an event. The block reports the height of the flat top above a baseline estimate, divided by `k`, so the result is the step height in input LSBs.

The input is a valid/ready stream. `in_ready` is held high at all times, because every sample is absorbed in the cycle it is offered. Only cycles with `in_valid` high advance the filter, so the upstream converter may leave gaps and the sample timing stays intact. No back-pressure exists on the output side. Each result is a one-cycle strobe that the consumer must take when it appears. The configuration inputs must be stable while samples flow. They are changed only while the input has been flat for at least 256 samples.

Top module: `trap_shaper`

## Requirements
- R1: `in_ready` is 1 in every cycle. A sample is consumed in each cycle with `in_valid` = 1. Cycles with `in_valid` = 0 do not advance the filter, the trigger or any sample count, and no result strobe appears in such a cycle.
- R2: After reset, `ev_valid` and `ev_pileup` are 0. They stay 0 until an event reaches its sample point.
- R3: The filter output is the running sum of d[n] = x[n] − x[n−k] − x[n−k−m] + x[n−2k−m], with 1 ≤ k and k + m ≤ 256. On a flat input, an isolated step of height h gives `ev_energy` = h. `ev_energy` is (filter − baseline) / k, truncated toward zero.
- R4: Take sample index S as the sample on which the trigger fires. The result strobe is then high for exactly one cycle. That cycle follows the cycle that consumed sample S + k + floor(m/2).
- R5: The baseline is the mean of the filter output over 64 consecutive samples that are not frozen. Any partial window is discarded when a freeze starts. The baseline is frozen while an event is in progress and during reset blanking. On a linear ramp of slope s with a step h on top, `ev_energy` = h.
- R6: The shaping settings k = 36, m = 8 and k = 80, m = 16 both yield the exact step height. Both yield the R4 timing.
- R7: A trigger fires on a sample where x[n] − x[n−4] > `trig_thresh` (strict). On the previous sample, that comparison must have been false. A flat-input step equal to the threshold causes no event. A step one LSB above it does cause one.
- R8: A second trigger may fire 1 to k + floor(m/2) − 1 samples after an event's trigger. The event is then a pile-up: at its sample point `ev_pileup` pulses for one cycle, and `ev_valid` stays 0.
- R9: Triggers from k + floor(m/2) up to 2k + m − 1 samples after an event's trigger are ignored, with no strobe of either kind. A trigger 2k + m samples after it starts a new event.
- R10: A reset is detected when x[n−1] − x[n] > `reset_drop`. It clears the accumulator and the filter history, and it aborts any event in progress, so no strobe follows. Triggers are then blocked for 2k + m samples. Later steps are measured correctly again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_sample | input | 20 | Signed preamplifier sample |
| rise_len | input | 9 | Rise length k in samples (1..256) |
| top_len | input | 9 | Flat-top length m in samples (k + m ≤ 256) |
| trig_thresh | input | 20 | Unsigned trigger threshold on the lag-4 difference |
| reset_drop | input | 20 | Unsigned drop size above which a preamp reset is declared |
| ev_valid | output | 1 | One-cycle strobe: `ev_energy` holds a new result |
| ev_energy | output | 24 | Signed event energy in input LSBs |
| ev_pileup | output | 1 | One-cycle strobe: the event was rejected as pile-up |

## Verification
The bench first applies isolated steps on a flat input. This separates the filter gain and the sample-point timing from any baseline effect. It then repeats a step on a steady ramp, where only correct pedestal subtraction gives the exact height. Step pairs at chosen spacings fall either inside the pile-up window or in the dead window. The spacings tell a rejected event apart from an ignored trigger and from a newly accepted one. Steps exactly at and one above the threshold probe the strict comparison. A large drop in the middle of an event, followed by a step during blanking, shows that both the abort and the blocking work. A gapped input stream and a second shaping setting confirm that timing is counted in samples and that the result scales by k.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  localparam int SAMPLE_W  = 20;
  localparam int ACC_W     = 32;
  localparam int OUT_W     = 24;
  localparam int MAX_DELAY = 256;
  localparam int AVG_LOG2  = 6;
  localparam int FAST_LAG  = 4;
endpackage

// File: rtl/trap_delay_line.sv
`timescale 1ns/1ps
// Circular-buffer delay with run-time length and a one-tick flush to a constant.
module trap_delay_line #(
  parameter int DATA_W = 21,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     flush,
  input  logic signed [DATA_W-1:0] fill,
  input  logic signed [DATA_W-1:0] din,
  input  logic [AW:0]              len,
  output logic signed [DATA_W-1:0] dout
);
  logic signed [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp;

  // len == DEPTH maps onto wp itself: the entry about to be overwritten.
  assign dout = mem[wp - AW'(len)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (en) begin
      if (flush) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= fill;
      end else begin
        mem[wp] <= din;
      end
      wp <= wp + AW'(1);
    end
  end
endmodule

// File: rtl/trap_baseline.sv
`timescale 1ns/1ps
// Block average of the filter output over 2**WIN_LOG2 unfrozen samples.
module trap_baseline #(
  parameter int ACC_W    = 32,
  parameter int WIN_LOG2 = 6,
  localparam int SUM_W   = ACC_W + WIN_LOG2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    freeze,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] base
);
  logic signed [SUM_W-1:0] sum, total;
  logic [WIN_LOG2-1:0] cnt;

  assign total = sum + SUM_W'(din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      cnt  <= '0;
      base <= '0;
    end else if (en) begin
      if (freeze) begin
        sum <= '0;
        cnt <= '0;
      end else if (cnt == '1) begin
        base <= ACC_W'(total >>> WIN_LOG2);
        sum  <= '0;
        cnt  <= '0;
      end else begin
        sum <= total;
        cnt <= cnt + WIN_LOG2'(1);
      end
    end
  end
endmodule

// File: rtl/trap_event_ctrl.sv
`timescale 1ns/1ps
// Event window, pile-up flag and reset blanking, all counted in samples.
module trap_event_ctrl #(
  parameter int LEN_W  = 9,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic             abort,
  input  logic [LEN_W-1:0] rise_len,
  input  logic [LEN_W-1:0] top_len,
  output logic             busy,
  output logic             blanked,
  output logic             take,
  output logic             take_pile
);
  logic [CNT_W-1:0] cnt, blank_cnt, spt, dead;
  logic pile;

  assign spt       = CNT_W'(rise_len) + CNT_W'(top_len >> 1);
  assign dead      = (CNT_W'(rise_len) << 1) + CNT_W'(top_len);
  assign blanked   = (blank_cnt != '0);
  assign take      = en && busy && !abort && (cnt == spt);
  assign take_pile = take && pile;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pile      <= 1'b0;
      cnt       <= '0;
      blank_cnt <= '0;
    end else if (en) begin
      if (abort) begin
        busy      <= 1'b0;
        pile      <= 1'b0;
        cnt       <= '0;
        blank_cnt <= dead;
      end else begin
        if (blanked) blank_cnt <= blank_cnt - CNT_W'(1);
        if (busy) begin
          if (hit && (cnt < spt)) pile <= 1'b1;
          if (cnt == dead - CNT_W'(1)) busy <= 1'b0;
          cnt <= cnt + CNT_W'(1);
        end else if (hit && !blanked) begin
          busy <= 1'b1;
          pile <= 1'b0;
          cnt  <= CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trap_shaper.sv
`timescale 1ns/1ps
module trap_shaper
  import trap_pkg::*;
#(
  parameter int SW    = SAMPLE_W,
  parameter int AW_   = ACC_W,
  parameter int OW    = OUT_W,
  parameter int DEPTH = MAX_DELAY,
  parameter int AVG_L = AVG_LOG2,
  parameter int LAG   = FAST_LAG,
  localparam int LEN_W = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_sample,
  input  logic [LEN_W-1:0]     rise_len,
  input  logic [LEN_W-1:0]     top_len,
  input  logic [SW-1:0]        trig_thresh,
  input  logic [SW-1:0]        reset_drop,
  output logic                 ev_valid,
  output logic signed [OW-1:0] ev_energy,
  output logic                 ev_pileup
);
  localparam int A_W    = SW + 1;
  localparam int D_W    = SW + 2;
  localparam int DIFF_W = AW_ + 1;

  logic tick, drop, cmp, cmp_q, hit;
  logic busy, blanked, take, take_pile;
  logic [LEN_W-1:0] span;
  logic signed [SW-1:0]     x_k, prev_x;
  logic signed [SW-1:0]     hist [LAG];
  logic signed [A_W-1:0]    a_now, a_old, fast;
  logic signed [D_W-1:0]    d_now;
  logic signed [AW_-1:0]    acc, base;
  logic signed [DIFF_W-1:0] diff, quo;

  assign in_ready = 1'b1;
  assign tick     = in_valid;
  assign span     = rise_len + top_len;

  // Reset detection and lag difference for the trigger.
  assign drop = tick && ((A_W'(prev_x) - A_W'(in_sample)) > $signed({1'b0, reset_drop}));
  assign fast = A_W'(in_sample) - A_W'(hist[LAG-1]);
  assign cmp  = fast > $signed({1'b0, trig_thresh});
  assign hit  = cmp && !cmp_q;

  // Recursive trapezoid: two delay-line differences feed one accumulator.
  trap_delay_line #(.DATA_W(SW), .DEPTH(DEPTH)) u_dly_x (
    .clk(clk), .rst_n(rst_n), .en(tick), .flush(drop),
    .fill(in_sample), .din(in_sample), .len(rise_len), .dout(x_k)
  );

  assign a_now = A_W'(in_sample) - A_W'(x_k);

  trap_delay_line #(.DATA_W(A_W), .DEPTH(DEPTH)) u_dly_a (
    .clk(clk), .rst_n(rst_n), .en(tick), .flush(drop),
    .fill('0), .din(a_now), .len(span), .dout(a_old)
  );

  assign d_now = D_W'(a_now) - D_W'(a_old);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      prev_x <= '0;
      cmp_q  <= 1'b0;
      for (int i = 0; i < LAG; i++) hist[i] <= '0;
    end else if (tick) begin
      prev_x <= in_sample;
      if (drop) begin
        acc   <= '0;
        cmp_q <= 1'b0;
        for (int i = 0; i < LAG; i++) hist[i] <= in_sample;
      end else begin
        acc   <= acc + AW_'(d_now);
        cmp_q <= cmp;
        hist[0] <= in_sample;
        for (int i = 1; i < LAG; i++) hist[i] <= hist[i-1];
      end
    end
  end

  trap_baseline #(.ACC_W(AW_), .WIN_LOG2(AVG_L)) u_base (
    .clk(clk), .rst_n(rst_n), .en(tick),
    .freeze(busy || blanked || drop), .din(acc), .base(base)
  );

  trap_event_ctrl #(.LEN_W(LEN_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .en(tick), .hit(hit), .abort(drop),
    .rise_len(rise_len), .top_len(top_len),
    .busy(busy), .blanked(blanked), .take(take), .take_pile(take_pile)
  );

  // Pedestal removal and gain normalization at the sample point.
  assign diff = DIFF_W'(acc) - DIFF_W'(base);
  assign quo  = diff / $signed(DIFF_W'({1'b0, rise_len}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid  <= 1'b0;
      ev_pileup <= 1'b0;
      ev_energy <= '0;
    end else begin
      ev_valid  <= take && !take_pile;
      ev_pileup <= take_pile;
      if (take) ev_energy <= OW'(quo);
    end
  end
endmodule

// File: rtl/trap_shaper_chk.sv
`timescale 1ns/1ps
module trap_shaper_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic ev_valid,
  input logic ev_pileup,
  input logic drop
);
  // R4: a result strobe lasts a single cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);

  // R8: a pile-up event never also reports an energy
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_pileup));

  // R1: strobes only follow a cycle that consumed a sample
  a_r1_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid || ev_pileup) |-> $past(in_valid));

  // R10: a reset drop aborts the event, so no strobe follows it
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!ev_valid && !ev_pileup));
endmodule

bind trap_shaper trap_shaper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .ev_valid(ev_valid), .ev_pileup(ev_pileup), .drop(drop)
);

// File: tb/trap_shaper_tb_top.sv
`timescale 1ns/1ps
module trap_shaper_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [19:0] in_sample = '0;
  logic [8:0] rise_len = 9'd36;
  logic [8:0] top_len = 9'd8;
  logic [19:0] trig_thresh = 20'd200;
  logic [19:0] reset_drop = 20'd5000;
  logic ev_valid, ev_pileup;
  logic signed [23:0] ev_energy;

  int errors = 0, checks = 0;
  int xv = 1000, idx = 0;
  int ev_n = 0, ev_e = 0, ev_idx = -1, pl_n = 0, pl_idx = -1;

  always #5 clk = ~clk;

  trap_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .rise_len(rise_len), .top_len(top_len),
    .trig_thresh(trig_thresh), .reset_drop(reset_drop),
    .ev_valid(ev_valid), .ev_energy(ev_energy), .ev_pileup(ev_pileup)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    if (ev_valid) begin ev_n++; ev_e = int'(ev_energy); ev_idx = idx; end
    if (ev_pileup) begin pl_n++; pl_idx = idx; end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 20'(v);
    @(posedge clk); #1;
    idx++;
    in_valid = 1'b0;
    observe();
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    if (ev_valid || ev_pileup) check("R1", "strobe in idle cycle", 1, 0);
    observe();
  endtask

  task automatic flat(input int n);
    for (int i = 0; i < n; i++) push(xv);
  endtask

  task automatic ramp(input int n, input int s);
    for (int i = 0; i < n; i++) begin xv += s; push(xv); end
  endtask

  function automatic int spt();
    return int'(rise_len) + int'(top_len) / 2;
  endfunction

  function automatic int dead();
    return 2 * int'(rise_len) + int'(top_len);
  endfunction

  task automatic t_reset_state();
    check("R2", "ev_valid after reset", int'(ev_valid), 0);
    check("R2", "ev_pileup after reset", int'(ev_pileup), 0);
    check("R1", "in_ready", int'(in_ready), 1);
  endtask

  task automatic t_flat_step(input int h, input string req);
    int n0, s;
    flat(400);
    n0 = ev_n;
    xv += h; push(xv); s = idx;
    flat(spt() + 10);
    check(req, "event count", ev_n - n0, 1);
    check(req, "energy", ev_e, h);
    check("R4", "strobe sample index", ev_idx, s + spt());
  endtask

  task automatic t_threshold();
    int n0, p0;
    flat(400);
    n0 = ev_n; p0 = pl_n;
    xv += 200; push(xv);
    flat(dead() + 20);
    check("R7", "step at threshold: events", ev_n - n0, 0);
    check("R7", "step at threshold: pileups", pl_n - p0, 0);
    t_flat_step(201, "R7");
  endtask

  task automatic t_gap();
    int n0, s;
    flat(400);
    n0 = ev_n;
    xv += 555; push(xv); s = idx;
    for (int i = 0; i < spt() + 10; i++) begin idle_cycle(); push(xv); end
    check("R1", "gapped event count", ev_n - n0, 1);
    check("R1", "gapped energy", ev_e, 555);
    check("R1", "gapped strobe index", ev_idx, s + spt());
  endtask

  task automatic t_pileup();
    int n0, p0, s;
    flat(400);
    n0 = ev_n; p0 = pl_n;
    xv += 700; push(xv); s = idx;
    flat(9);
    xv += 700; push(xv);
    flat(dead() + 20);
    check("R8", "pile-up energy strobes", ev_n - n0, 0);
    check("R8", "pile-up strobes", pl_n - p0, 1);
    check("R8", "pile-up strobe index", pl_idx, s + spt());
  endtask

  task automatic t_dead_window();
    int n0, p0, s;
    flat(400);
    n0 = ev_n; p0 = pl_n;
    xv += 600; push(xv); s = idx;
    while (idx < s + 44) push(xv);
    check("R9", "first event count", ev_n - n0, 1);
    check("R9", "first energy", ev_e, 600);
    xv += 400; push(xv);
    while (idx < s + dead() - 1) push(xv);
    xv += 300; push(xv);
    check("R9", "accept index", idx, s + dead());
    flat(spt() + 10);
    check("R9", "events over window", ev_n - n0, 2);
    check("R9", "pileups over window", pl_n - p0, 0);
    check("R9", "second accepted strobe index", ev_idx, s + dead() + spt());
  endtask

  task automatic t_ramp();
    int n0, s;
    ramp(400, 3);
    n0 = ev_n;
    xv += 3 + 1000; push(xv); s = idx;
    ramp(spt() + 10, 3);
    check("R5", "ramp event count", ev_n - n0, 1);
    check("R5", "ramp energy", ev_e, 1000);
    check("R5", "ramp strobe index", ev_idx, s + spt());
    flat(400);
  endtask

  task automatic t_reset_drop();
    int n0, p0, d;
    flat(400);
    n0 = ev_n; p0 = pl_n;
    xv += 800; push(xv);
    flat(9);
    xv -= 6000; push(xv); d = idx;
    flat(5);
    xv += 900; push(xv);
    flat(dead() + spt() + 20);
    check("R10", "energy strobes after drop", ev_n - n0, 0);
    check("R10", "pile-up strobes after drop", pl_n - p0, 0);
    check("R10", "drop index", d > 0 ? 1 : 0, 1);
    t_flat_step(500, "R10");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_state();
    t_flat_step(1000, "R3");
    t_threshold();
    t_gap();
    t_pileup();
    t_dead_window();
    t_ramp();
    flat(300);
    rise_len = 9'd80; top_len = 9'd16;
    t_flat_step(777, "R6");
    t_flat_step(2345, "R6");
    flat(300);
    rise_len = 9'd36; top_len = 9'd8;
    t_flat_step(321, "R6");
    t_reset_drop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule